// File: doc/BRIEF.md
# Pointer-Addressed Console Port Controller

This block is a minimal memory-mapped console port with two byte-wide locations on a simple register bus: a control/status location and a data location. Writing the control location loads an internal selector byte. The selector decides what the next status read returns. Normally a status read returns a fixed status byte. When the selector holds 3, the next status read returns a single interrupt-cause byte instead, and that read returns the selector to 0.

The port keeps two pending flags, one for transmit and one for receive, and drives one interrupt line. Received bytes come in on a ready/valid stream and wait in a small queue until software pops them through the data location. Writing the data location sends the byte out on a valid-qualified transmit stream. Each such write immediately raises the transmit-pending flag and the interrupt. Software clears the transmit flag with a dedicated acknowledge command written to the control location.

Two misuses are reported on a one-cycle error pulse: an acknowledge while no transmit is pending, and a data read while the receive queue is empty. No enable mask gates the interrupt.

Top module: `cport_ctrl`

## Requirements
- R1: After reset:
  - `irq`, `tx_valid` and `bus_err` are 0.
  - `rx_ready` is 1.
  - A status read returns 0x04.
- R2: Any write to the control location (offset 0x80) loads the written byte into the selector. Writes of 0x00, 0x01 and 0x12 change nothing else: the interrupt, the error pulse and both pending flags keep their values.
- R3: With the selector equal to 3, a status read returns:
  - 0x10 if transmit is pending;
  - otherwise 0x20 if receive is pending;
  - otherwise 0x00.

  That read sets the selector back to 0, so the following status read returns the normal status byte.
- R4: A write to the data location (offset 0xC0) makes `tx_valid` pulse for one cycle with `tx_data` equal to the written byte. The same write sets transmit pending and raises `irq`. All three are visible the cycle after the access.
- R5: A control write of 0x28 while transmit is pending clears transmit pending and drops `irq`, even when receive is still pending.
- R6: A control write of 0x28 while transmit is not pending produces a one-cycle `bus_err` pulse and leaves `irq` unchanged.
- R7: A byte is accepted when `rx_valid` and `rx_ready` are both high. Acceptance sets receive pending and raises `irq`. A status read with the selector not equal to 3 returns 0x04 with bit 0 set while receive is pending (0x05).
- R8: A data read returns the oldest queued byte and removes it from the queue.
  - If bytes remain after the read, `irq` keeps its value.
  - If the queue becomes empty, receive pending clears and `irq` drops.
- R9: A data read with an empty queue returns 0x00 and produces a one-cycle `bus_err` pulse.
- R10: When the receive queue holds RX_DEPTH bytes (default 4), `rx_ready` is low and a presented byte is not accepted.
- R11: A byte accepted in the same cycle as a clearing event (an acknowledge, or the pop of the last queued byte) wins: `irq` stays high and receive pending stays set.
- R12: Accesses to any offset other than 0x80 and 0xC0 change nothing. Reads of such offsets return 0x00. Every read, mapped or not, returns its byte on `bus_rdata` with a one-cycle `bus_rvalid` pulse, one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| bus_rvalid | output | 1 | Pulses the cycle after each read |
| bus_err | output | 1 | One-cycle pulse on an illegal acknowledge or an empty data read |
| irq | output | 1 | Console interrupt, registered |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive queue can accept a byte |
| tx_valid | output | 1 | Transmit byte valid, one-cycle pulse |
| tx_data | output | 8 | Transmit byte |

## Verification
Receive arrival is independent of the register bus, so an arriving byte can coincide with either of the two bus events that lower the interrupt. The first is a data read that pops the last queued byte. The second is an acknowledge of a pending transmit. The bench drives `rx_valid` in the very cycle of each such access. It then checks three things: that `irq` is still high afterwards, that a cause read shows receive pending, and that the new byte is the next one popped.

// File: rtl/cport_pkg.sv
package cport_pkg;

  // Selector value that turns the next status read into a cause read.
  localparam logic [7:0] CAUSE_SEL = 8'h03;
  // Control command that acknowledges a pending transmit interrupt.
  localparam logic [7:0] ACK_CMD   = 8'h28;

  // Bit positions in the returned status / cause bytes.
  localparam int STAT_RX_BIT    = 0;
  localparam int STAT_FIXED_BIT = 2;
  localparam int CAUSE_TX_BIT   = 4;
  localparam int CAUSE_RX_BIT   = 5;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTRL_WR,
    ACC_CTRL_RD,
    ACC_DATA_WR,
    ACC_DATA_RD,
    ACC_OTHER_RD
  } acc_e;

endpackage

// File: rtl/cport_rst_sync.sv
module cport_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sh_q <= '0;
    else              sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/cport_rx_fifo.sv
module cport_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty,
  output logic          last
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  assign head  = mem_q[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign last  = (cnt_q == CW'(1));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/cport_cause.sv
module cport_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_set,
  input  logic tx_ack,
  input  logic rx_arrive,
  input  logic rx_drained,
  output logic tx_pend,
  output logic rx_pend,
  output logic irq,
  output logic ack_err
);

  logic tx_q, tx_d, rx_q, rx_d, irq_q, irq_d;
  logic ack_ok;

  always_comb begin
    ack_ok  = tx_ack && tx_q;
    ack_err = tx_ack && !tx_q;

    tx_d = tx_q;
    if (tx_set)      tx_d = 1'b1;
    else if (ack_ok) tx_d = 1'b0;

    rx_d = rx_q;
    if (rx_arrive)       rx_d = 1'b1;
    else if (rx_drained) rx_d = 1'b0;

    irq_d = irq_q;
    if (tx_set || rx_arrive)       irq_d = 1'b1;
    else if (ack_ok || rx_drained) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      irq_q <= irq_d;
    end
  end

  assign tx_pend = tx_q;
  assign rx_pend = rx_q;
  assign irq     = irq_q;

  // R7
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(tx_set || rx_arrive));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && tx_pend && !rx_arrive) |=> (!irq_q && !tx_q));

  // R11
  arrive_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_arrive |=> (irq_q && rx_q));

endmodule

// File: rtl/cport_ctrl.sv
module cport_ctrl
  import cport_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter int                RX_DEPTH = 4,
  parameter int                SYNC_STG = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h80,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);

  logic rst_q_n;

  cport_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_q_n)
  );

  // Access decode
  acc_e acc;
  logic ctrl_wr, ctrl_rd, data_wr, data_rd, any_rd;

  always_comb begin
    acc = ACC_NONE;
    if (bus_sel) begin
      if (bus_addr == CTRL_OFS)      acc = bus_we ? ACC_CTRL_WR : ACC_CTRL_RD;
      else if (bus_addr == DATA_OFS) acc = bus_we ? ACC_DATA_WR : ACC_DATA_RD;
      else if (!bus_we)              acc = ACC_OTHER_RD;
    end
    ctrl_wr = (acc == ACC_CTRL_WR);
    ctrl_rd = (acc == ACC_CTRL_RD);
    data_wr = (acc == ACC_DATA_WR);
    data_rd = (acc == ACC_DATA_RD);
    any_rd  = ctrl_rd || data_rd || (acc == ACC_OTHER_RD);
  end

  // Receive queue
  logic              fifo_full, fifo_empty, fifo_last;
  logic [DATA_W-1:0] fifo_head;
  logic              rx_push, rx_pop, rx_drained;

  assign rx_ready   = !fifo_full && rst_q_n;
  assign rx_push    = rx_valid && rx_ready;
  assign rx_pop     = data_rd && !fifo_empty;
  assign rx_drained = rx_pop && fifo_last && !rx_push;

  cport_rx_fifo #(.DW(DATA_W), .DEPTH(RX_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .push      (rx_push),
    .push_data (rx_data),
    .pop       (rx_pop),
    .head      (fifo_head),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .last      (fifo_last)
  );

  // Pending flags and interrupt
  logic tx_pend, rx_pend, ack_err, tx_ack;

  assign tx_ack = ctrl_wr && (bus_wdata == DATA_W'(ACK_CMD));

  cport_cause u_cause (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .tx_set     (data_wr),
    .tx_ack     (tx_ack),
    .rx_arrive  (rx_push),
    .rx_drained (rx_drained),
    .tx_pend    (tx_pend),
    .rx_pend    (rx_pend),
    .irq        (irq),
    .ack_err    (ack_err)
  );

  // Selector, read data, error and transmit registers
  logic [DATA_W-1:0] ptr_q, ptr_d, rd_q, rd_d, txd_q;
  logic              rv_q, err_q, err_d, txv_q, cause_rd;

  always_comb begin
    cause_rd = ctrl_rd && (ptr_q == DATA_W'(CAUSE_SEL));

    ptr_d = ptr_q;
    if (ctrl_wr)       ptr_d = bus_wdata;
    else if (cause_rd) ptr_d = '0;

    rd_d = '0;
    if (cause_rd) begin
      if (tx_pend)      rd_d[CAUSE_TX_BIT] = 1'b1;
      else if (rx_pend) rd_d[CAUSE_RX_BIT] = 1'b1;
    end else if (ctrl_rd) begin
      rd_d[STAT_FIXED_BIT] = 1'b1;
      rd_d[STAT_RX_BIT]    = rx_pend;
    end else if (rx_pop) begin
      rd_d = fifo_head;
    end

    err_d = ack_err || (data_rd && fifo_empty);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ptr_q <= '0;
      rd_q  <= '0;
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      rv_q  <= any_rd;
      err_q <= err_d;
      txv_q <= data_wr;
      if (any_rd)  rd_q  <= rd_d;
      if (data_wr) txd_q <= bus_wdata;
    end
  end

  assign bus_rdata  = rd_q;
  assign bus_rvalid = rv_q;
  assign bus_err    = err_q;
  assign tx_valid   = txv_q;
  assign tx_data    = txd_q;

  // R8
  rx_pend_mirror_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_pend == !fifo_empty);

  // R9
  empty_read_err_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (data_rd && fifo_empty) |=> (bus_err && bus_rdata == '0 && bus_rvalid));

  // R4
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    data_wr |=> (tx_valid && irq && tx_data == $past(bus_wdata)));

  // R3
  cause_rearm_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cause_rd |=> (ptr_q == '0));

endmodule

// File: tb/cport_ctrl_tb.sv
`timescale 1ns/1ps
module cport_ctrl_tb;

  localparam logic [7:0] CTRL = 8'h80;
  localparam logic [7:0] DATA = 8'hC0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, bus_err, irq;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit live   = 1'b0;
  bit done   = 1'b0;

  logic [7:0] rd_q [$];
  string      rd_tag [$];
  logic [7:0] tx_q [$];

  always #4 clk = ~clk;

  cport_ctrl u_dut (
    .clk (clk), .rst_n (rst_n),
    .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .bus_err (bus_err), .irq (irq),
    .rx_valid (rx_valid), .rx_data (rx_data), .rx_ready (rx_ready),
    .tx_valid (tx_valid), .tx_data (tx_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus access, optionally with a receive byte offered in the same cycle.
  task automatic acc(input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic rv = 1'b0, input logic [7:0] rd = 8'h00);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rd;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d,
                    input logic rv = 1'b0, input logic [7:0] rd = 8'h00);
    if (a == DATA) tx_q.push_back(d);
    acc(1'b1, a, d, rv, rd);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag,
                    input logic rv = 1'b0, input logic [7:0] rdv = 8'h00);
    rd_q.push_back(exp);
    rd_tag.push_back(tag);
    acc(1'b0, a, 8'h00, rv, rdv);
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Monitor: pops expected read bytes and transmit bytes as they appear.
  always @(negedge clk) begin
    if (live) begin
      if (bus_rvalid) begin
        if (rd_q.size() == 0) chk("R12 unexpected rvalid", 1, 0);
        else chk(rd_tag.pop_front(), bus_rdata, rd_q.pop_front());
      end
      if (tx_valid) begin
        if (tx_q.size() == 0) chk("R4/R12 unexpected tx", tx_data, 0);
        else chk("R4 tx_data", tx_data, tx_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 bus_err", bus_err, 0);
    chk("R1 rx_ready", rx_ready, 1);
    rd(CTRL, 8'h04, "R1 status after reset");

    // R2 plain selector writes
    wr(CTRL, 8'h12);
    rd(CTRL, 8'h04, "R2 status after 0x12");
    // R3 cause read with nothing pending, then selector back to 0
    wr(CTRL, 8'h03);
    rd(CTRL, 8'h00, "R3 cause none");
    rd(CTRL, 8'h04, "R3 selector rearmed");

    // R4 transmit
    wr(DATA, 8'h41);
    chk("R4 irq", irq, 1);
    wr(CTRL, 8'h12); wr(CTRL, 8'h01); wr(CTRL, 8'h00);
    chk("R2 irq kept", irq, 1);
    chk("R2 no err", bus_err, 0);
    wr(CTRL, 8'h03);
    rd(CTRL, 8'h10, "R3 cause tx");

    // R5 acknowledge, R6 illegal acknowledge
    wr(CTRL, 8'h28);
    chk("R5 irq dropped", irq, 0);
    chk("R5 no err", bus_err, 0);
    wr(CTRL, 8'h28);
    chk("R6 err pulse", bus_err, 1);
    chk("R6 irq unchanged", irq, 0);

    // R7 receive
    rx_send(8'h55);
    chk("R7 irq", irq, 1);
    rx_send(8'h66);
    rd(CTRL, 8'h05, "R7 status rx");
    wr(CTRL, 8'h03);
    rd(CTRL, 8'h20, "R3 cause rx");
    wr(DATA, 8'h77);
    wr(CTRL, 8'h03);
    rd(CTRL, 8'h10, "R3 tx has priority");
    wr(CTRL, 8'h28);
    chk("R5 irq dropped with rx pending", irq, 0);
    rd(CTRL, 8'h05, "R5 rx still pending");

    // R8 pops in order
    rd(DATA, 8'h55, "R8 first pop");
    chk("R8 irq kept on non-last pop", irq, 0);
    rd(DATA, 8'h66, "R8 second pop");
    rd(CTRL, 8'h04, "R8 rx cleared");

    // R9 empty read
    rd(DATA, 8'h00, "R9 empty read");
    chk("R9 err", bus_err, 1);

    // R10 queue full
    for (int i = 0; i < 4; i++) rx_send(8'hA0 + 8'(i));
    chk("R10 rx_ready low", rx_ready, 0);
    rx_send(8'hEE);
    for (int i = 0; i < 3; i++) begin
      rd(DATA, 8'hA0 + 8'(i), "R10 drain");
      chk("R8 irq kept", irq, 1);
    end
    rd(DATA, 8'hA3, "R10 drain last");
    chk("R8 irq dropped on last pop", irq, 0);
    rd(DATA, 8'h00, "R10 dropped byte absent");
    chk("R10 err on empty", bus_err, 1);

    // R11 arrival beats last pop and acknowledge
    rx_send(8'h11);
    rd(DATA, 8'h11, "R11 pop with arrival", 1'b1, 8'h22);
    chk("R11 irq kept over last pop", irq, 1);
    rd(CTRL, 8'h05, "R11 rx pending");
    rd(DATA, 8'h22, "R11 arrived byte");
    chk("R8 irq low", irq, 0);
    wr(DATA, 8'h33);
    wr(CTRL, 8'h28, 1'b1, 8'h44);
    chk("R11 irq kept over ack", irq, 1);
    chk("R11 no err", bus_err, 0);
    wr(CTRL, 8'h03);
    rd(CTRL, 8'h20, "R11 tx cleared rx pending");
    rd(DATA, 8'h44, "R11 ack-cycle byte");

    // R12 unmapped offsets
    rx_send(8'h5A);
    wr(8'h40, 8'h99);
    rd(8'h40, 8'h00, "R12 unmapped read");
    wr(8'h10, 8'h03);
    rd(CTRL, 8'h05, "R12 selector untouched");
    rd(DATA, 8'h5A, "R12 no pop by unmapped read");
    chk("R12 irq low after drain", irq, 0);

    repeat (3) @(negedge clk);
    chk("R12 all reads answered", rd_q.size(), 0);
    chk("R4 all tx seen", tx_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule